// File: doc/BRIEF.md
# Transaction Receive Reordering Queue

This block buffers received transaction-layer packets for a single virtual channel and delivers them to the application in two phases. In the descriptor phase the block raises a request with the packet's descriptor and class, and the application ends the phase with an acknowledge. Packets that carry payload then enter a data phase: 64-bit beats with byte enables, which the application can throttle with a wait input. Every packet returns its flow-control credit as a one-cycle pulse on the output for its class, and only after both phases are over.

Arrival order is kept everywhere except around a non-posted request that the application cannot take. The application can retry a presented non-posted request, which lets queued posted and completion packets go ahead of it. It can also hold a mask high to keep all non-posted requests back. Non-posted requests never overtake one another, and posted and completion packets never overtake each other. The queue holds eight packets of up to four beats each. Ingress uses a valid/ready pair, and each accepted packet arrives whole in one cycle. No other channel shares this state, so a stalled channel cannot hold up any other channel.

Top module: `rx_order_queue`

## Requirements
- R1: After a synchronous active-low reset, `dsc_req`, `dat_valid` and all three credit pulses are low and `in_ready` is high.
- R2: With no retry and no mask, packets are presented in arrival order. This holds whatever their class, and neither a relaxed-ordering attribute nor a traffic class held in the descriptor changes it.
- R3: The class code is 00 for posted, 01 for non-posted and 10 for completion. While `np_mask` is high, no non-posted packet starts a descriptor phase. Posted and completion packets queued behind a masked request are still delivered.
- R4: A retry (`dsc_retry` high with `dsc_ack` low) on a presented non-posted packet ends its descriptor phase. The oldest queued posted or completion packet is presented next. The retried request stays queued, and a later non-posted request is never presented before it.
- R5: A retry on a presented posted or completion packet is ignored: `dsc_req` stays high with the same descriptor.
- R6: Once `dsc_req` is high, the descriptor and class stay stable until the cycle in which `dsc_ack` is sampled high.
- R7: Data beats come out in stored order with their byte enables, starting the cycle after the acknowledge. A cycle with `dat_wait` high holds the current beat unchanged.
- R8: Exactly one credit pulse, on the output matching the packet class, comes one cycle after the acknowledge for a packet without data, or one cycle after the last accepted beat. No pulse appears while the packet's phases are still running.
- R9: `in_ready` is low while eight packets are stored, and a packet offered in that state is dropped.
- R10: `dsc_dfr` is high throughout a descriptor phase exactly when the packet has one or more data beats.
- R11: A retried non-posted request with no other packet that can go ahead of it is presented again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Ingress packet offered |
| in_ready | output | 1 | Queue has room |
| in_cls | input | 2 | Ingress class: 00 posted, 01 non-posted, 10 completion |
| in_desc | input | 64 | Ingress descriptor |
| in_beats | input | 3 | Number of data beats, 0 to 4 |
| in_data | input | 256 | Data beats, beat 0 in the low 64 bits |
| in_be | input | 32 | Byte enables, beat 0 in the low 8 bits |
| np_mask | input | 1 | Hold back non-posted packets |
| dsc_req | output | 1 | Descriptor phase active |
| dsc_desc | output | 64 | Presented descriptor |
| dsc_cls | output | 2 | Presented class |
| dsc_dfr | output | 1 | Presented packet has data |
| dsc_ack | input | 1 | Application accepts descriptor |
| dsc_retry | input | 1 | Application defers a non-posted request |
| dat_valid | output | 1 | Data beat present |
| dat_wait | input | 1 | Application holds the current beat |
| dat_out | output | 64 | Data beat |
| dat_be | output | 8 | Byte enables of the beat |
| crd_post | output | 1 | Posted credit release pulse |
| crd_np | output | 1 | Non-posted credit release pulse |
| crd_cpl | output | 1 | Completion credit release pulse |

## Verification
The assertions assume that `in_beats` never exceeds four and `in_cls` never takes the unused code 11. They also assume `dsc_ack` and `dsc_retry` are driven only while `dsc_req` is high, and that `np_mask` changes only while no descriptor is being presented. The stimulus keeps to these limits. Its application model changes the mask only between packets, never raises acknowledge and retry together, and builds every packet from a helper that bounds the beat count and class. Under these limits the bench checks ordering, mask behaviour, retries, beat holding and credit timing.

// File: rtl/rxq_pkg.sv
// Shared types for the receive reordering queue.
// Assumes beats are 64 bits wide and packets carry at most four beats.
package rxq_pkg;
    localparam int unsigned DESC_W     = 64;
    localparam int unsigned BEAT_W     = 64;
    localparam int unsigned BE_W       = BEAT_W / 8;
    localparam int unsigned MAX_BEATS  = 4;
    localparam int unsigned BEAT_CNT_W = $clog2(MAX_BEATS + 1);
    localparam int unsigned BEAT_IDX_W = $clog2(MAX_BEATS);

    typedef enum logic [1:0] {
        CLS_POST    = 2'b00,
        CLS_NONPOST = 2'b01,
        CLS_CPL     = 2'b10
    } pkt_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_DESC = 2'b01,
        ST_DATA = 2'b10
    } xfer_st_e;

    typedef struct packed {
        pkt_cls_e                              cls;
        logic [DESC_W-1:0]                     desc;
        logic [BEAT_CNT_W-1:0]                 beats;
        logic [MAX_BEATS-1:0][BEAT_W-1:0]      data;
        logic [MAX_BEATS-1:0][BE_W-1:0]        be;
    } pkt_t;
endpackage

// File: rtl/rxq_store.sv
// Age-ordered packet store. Slot 0 holds the oldest packet, and removing a
// slot shifts every younger packet down by one. Writes append behind the
// youngest packet.
// Assumes the caller never pushes while full and pops only an occupied slot.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push,
    input  pkt_t                   push_pkt,
    input  logic                   pop,
    input  logic [IDX_W-1:0]       pop_idx,
    output pkt_t [DEPTH-1:0]       slots,
    output logic [DEPTH-1:0]       occ,
    output logic                   full
);
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  wr_pos;
    pkt_t [DEPTH-1:0]  slots_nxt;

    // Next slot contents: close the gap left by a pop, then append a push.
    always_comb begin
        slots_nxt = slots;
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (pop && (IDX_W'(i) >= pop_idx)) begin
                slots_nxt[i] = slots[i + 1];
            end
        end
        wr_pos = count - CNT_W'(pop);
        if (push) begin
            slots_nxt[wr_pos[IDX_W-1:0]] = push_pkt;
        end
    end

    // Slot payload register; contents beyond the count are don't-care.
    always_ff @(posedge clk) begin
        slots <= slots_nxt;
    end

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Occupancy flags in age order.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            occ[i] = (CNT_W'(i) < count);
        end
    end

    assign full = (count == CNT_W'(DEPTH));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CNT_W'(DEPTH)));

    assert_pop_occupied_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (CNT_W'(pop_idx) < count));
endmodule

// File: rtl/rxq_pick.sv
// Chooses the next packet to present. It scans in age order. Posted and
// completion packets are always eligible. Only the oldest non-posted packet
// may go, and only when unmasked and not deferred by a retry. If nothing else
// is eligible, a deferred but unmasked oldest non-posted packet is chosen.
// Assumes occ is a contiguous run of ones from slot 0.
module rxq_pick
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  pkt_cls_e [DEPTH-1:0]   cls_vec,
    input  logic [DEPTH-1:0]       occ,
    input  logic                   np_mask,
    input  logic                   np_defer,
    output logic                   pick_vld,
    output logic [IDX_W-1:0]       pick_idx
);
    logic             np_seen;
    logic             a_hit, b_hit;
    logic [IDX_W-1:0] a_idx, b_idx;
    logic             is_np;

    // Oldest-first scan with a fallback for a deferred head request.
    always_comb begin
        np_seen = 1'b0;
        a_hit   = 1'b0;
        b_hit   = 1'b0;
        a_idx   = '0;
        b_idx   = '0;
        is_np   = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (occ[i]) begin
                is_np = (cls_vec[i] == CLS_NONPOST);
                if (!is_np) begin
                    if (!a_hit) begin
                        a_hit = 1'b1;
                        a_idx = IDX_W'(i);
                    end
                end else if (!np_seen && !np_mask) begin
                    if (!np_defer) begin
                        if (!a_hit) begin
                            a_hit = 1'b1;
                            a_idx = IDX_W'(i);
                        end
                    end else begin
                        b_hit = 1'b1;
                        b_idx = IDX_W'(i);
                    end
                end
                if (is_np) begin
                    np_seen = 1'b1;
                end
            end
        end
        pick_vld = a_hit || b_hit;
        pick_idx = a_hit ? a_idx : b_idx;
    end
endmodule

// File: rtl/rxq_xfer.sv
// Handshake engine: it presents the chosen packet, handles acknowledge and
// retry, streams the data beats under wait-state control and pulses the
// class credit once both phases have ended.
// Assumes ack and retry are driven only while dsc_req is high.
module rxq_xfer
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  pkt_t [DEPTH-1:0]       slots,
    input  logic                   pick_vld,
    input  logic [IDX_W-1:0]       pick_idx,
    input  logic                   np_mask,
    input  logic                   dsc_ack,
    input  logic                   dsc_retry,
    input  logic                   dat_wait,
    output logic                   pop,
    output logic [IDX_W-1:0]       pop_idx,
    output logic                   np_defer,
    output logic                   dsc_req,
    output logic [DESC_W-1:0]      dsc_desc,
    output logic [1:0]             dsc_cls,
    output logic                   dsc_dfr,
    output logic                   dat_valid,
    output logic [BEAT_W-1:0]      dat_out,
    output logic [BE_W-1:0]        dat_be,
    output logic                   crd_post,
    output logic                   crd_np,
    output logic                   crd_cpl
);
    xfer_st_e                          state;
    logic [IDX_W-1:0]                  cur_idx;
    pkt_t                              cur;
    logic [MAX_BEATS-1:0][BEAT_W-1:0]  act_data;
    logic [MAX_BEATS-1:0][BE_W-1:0]    act_be;
    logic [BEAT_CNT_W-1:0]             act_beats;
    pkt_cls_e                          act_cls;
    logic [BEAT_IDX_W-1:0]             beat_idx;
    logic                              acc, rty, beat_take, last_beat, done;
    pkt_cls_e                          done_cls;

    // Presented packet and handshake decode.
    always_comb begin
        cur       = slots[cur_idx];
        dsc_req   = (state == ST_DESC);
        dsc_desc  = cur.desc;
        dsc_cls   = cur.cls;
        dsc_dfr   = dsc_req && (cur.beats != '0);
        acc       = dsc_req && dsc_ack;
        rty       = dsc_req && !dsc_ack && dsc_retry && (cur.cls == CLS_NONPOST);
        pop       = acc;
        pop_idx   = cur_idx;
        dat_valid = (state == ST_DATA);
        dat_out   = act_data[beat_idx];
        dat_be    = act_be[beat_idx];
        beat_take = dat_valid && !dat_wait;
        last_beat = ((BEAT_CNT_W'(beat_idx) + BEAT_CNT_W'(1)) == act_beats);
        done      = (acc && (cur.beats == '0)) || (beat_take && last_beat);
        done_cls  = acc ? cur.cls : act_cls;
    end

    // Phase sequencing and capture of the accepted packet's payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_idx   <= '0;
            beat_idx  <= '0;
            act_beats <= '0;
            act_cls   <= CLS_POST;
            act_data  <= '0;
            act_be    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pick_vld) begin
                        state   <= ST_DESC;
                        cur_idx <= pick_idx;
                    end
                end
                ST_DESC: begin
                    if (acc) begin
                        act_data  <= cur.data;
                        act_be    <= cur.be;
                        act_beats <= cur.beats;
                        act_cls   <= cur.cls;
                        beat_idx  <= '0;
                        state     <= (cur.beats != '0) ? ST_DATA : ST_IDLE;
                    end else if (rty) begin
                        state <= ST_IDLE;
                    end
                end
                ST_DATA: begin
                    if (beat_take) begin
                        if (last_beat) begin
                            state <= ST_IDLE;
                        end else begin
                            beat_idx <= beat_idx + BEAT_IDX_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Deferral flag for the oldest non-posted request; any acceptance clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            np_defer <= 1'b0;
        end else if (acc) begin
            np_defer <= 1'b0;
        end else if (rty) begin
            np_defer <= 1'b1;
        end
    end

    // Class credit pulses one cycle after both phases end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crd_post <= 1'b0;
            crd_np   <= 1'b0;
            crd_cpl  <= 1'b0;
        end else begin
            crd_np   <= done && (done_cls == CLS_NONPOST);
            crd_cpl  <= done && (done_cls == CLS_CPL);
            crd_post <= done && (done_cls != CLS_NONPOST) && (done_cls != CLS_CPL);
        end
    end

    assert_np_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dsc_req) && (dsc_cls == CLS_NONPOST)) |-> !$past(np_mask));

    assert_retry_leaves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_req && dsc_retry && !dsc_ack && (dsc_cls == CLS_NONPOST)) |=> !dsc_req);

    assert_desc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_req && !dsc_ack && !(dsc_retry && (dsc_cls == CLS_NONPOST)))
        |=> (dsc_req && $stable(dsc_desc) && $stable(dsc_cls)));

    assert_beat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && dat_wait) |=> (dat_valid && $stable(dat_out) && $stable(dat_be)));

    assert_credit_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({crd_post, crd_np, crd_cpl}) <= 1);

    assert_credit_after_phases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (crd_post || crd_np || crd_cpl) |-> (!dsc_req && !dat_valid));

    assert_data_follows_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dat_valid) |-> $past(dsc_dfr && dsc_ack));
endmodule

// File: rtl/rx_order_queue.sv
// Top of the single-channel receive reordering queue. It ties together the
// age-ordered store, the packet picker and the handshake engine.
// Assumes in_beats <= 4 and in_cls is never 2'b11.
module rx_order_queue
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [1:0]                    in_cls,
    input  logic [DESC_W-1:0]             in_desc,
    input  logic [BEAT_CNT_W-1:0]         in_beats,
    input  logic [MAX_BEATS*BEAT_W-1:0]   in_data,
    input  logic [MAX_BEATS*BE_W-1:0]     in_be,
    input  logic                          np_mask,
    output logic                          dsc_req,
    output logic [DESC_W-1:0]             dsc_desc,
    output logic [1:0]                    dsc_cls,
    output logic                          dsc_dfr,
    input  logic                          dsc_ack,
    input  logic                          dsc_retry,
    output logic                          dat_valid,
    input  logic                          dat_wait,
    output logic [BEAT_W-1:0]             dat_out,
    output logic [BE_W-1:0]               dat_be,
    output logic                          crd_post,
    output logic                          crd_np,
    output logic                          crd_cpl
);
    localparam int unsigned IDX_W = $clog2(DEPTH);

    pkt_t                   push_pkt;
    pkt_t [DEPTH-1:0]       slots;
    pkt_cls_e [DEPTH-1:0]   cls_vec;
    logic [DEPTH-1:0]       occ;
    logic                   full, push, pop, np_defer, pick_vld;
    logic [IDX_W-1:0]       pop_idx, pick_idx;

    // Ingress packing and acceptance.
    always_comb begin
        push_pkt.cls   = pkt_cls_e'(in_cls);
        push_pkt.desc  = in_desc;
        push_pkt.beats = in_beats;
        push_pkt.data  = in_data;
        push_pkt.be    = in_be;
        in_ready       = !full;
        push           = in_valid && !full;
    end

    // Class view of every slot for the picker.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cls
        assign cls_vec[g] = slots[g].cls;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_pkt (push_pkt),
        .pop      (pop),
        .pop_idx  (pop_idx),
        .slots    (slots),
        .occ      (occ),
        .full     (full)
    );

    rxq_pick #(.DEPTH(DEPTH)) u_pick (
        .cls_vec  (cls_vec),
        .occ      (occ),
        .np_mask  (np_mask),
        .np_defer (np_defer),
        .pick_vld (pick_vld),
        .pick_idx (pick_idx)
    );

    rxq_xfer #(.DEPTH(DEPTH)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .slots     (slots),
        .pick_vld  (pick_vld),
        .pick_idx  (pick_idx),
        .np_mask   (np_mask),
        .dsc_ack   (dsc_ack),
        .dsc_retry (dsc_retry),
        .dat_wait  (dat_wait),
        .pop       (pop),
        .pop_idx   (pop_idx),
        .np_defer  (np_defer),
        .dsc_req   (dsc_req),
        .dsc_desc  (dsc_desc),
        .dsc_cls   (dsc_cls),
        .dsc_dfr   (dsc_dfr),
        .dat_valid (dat_valid),
        .dat_out   (dat_out),
        .dat_be    (dat_be),
        .crd_post  (crd_post),
        .crd_np    (crd_np),
        .crd_cpl   (crd_cpl)
    );
endmodule

// File: tb/test_rx_order_queue.sv
`timescale 1ns/1ps
module test_rx_order_queue;
    import rxq_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0, in_ready;
    logic [1:0]   in_cls = '0;
    logic [63:0]  in_desc = '0;
    logic [2:0]   in_beats = '0;
    logic [255:0] in_data = '0;
    logic [31:0]  in_be = '0;
    logic         np_mask = 1'b0;
    logic         dsc_req, dsc_dfr, dat_valid;
    logic [63:0]  dsc_desc, dat_out;
    logic [1:0]   dsc_cls;
    logic         dsc_ack = 1'b0, dsc_retry = 1'b0, dat_wait = 1'b0;
    logic [7:0]   dat_be;
    logic         crd_post, crd_np, crd_cpl;

    rx_order_queue i_rx_order_queue (.*);

    typedef struct packed {
        logic [63:0]      desc;
        logic [1:0]       cls;
        logic [2:0]       beats;
        logic [3:0][63:0] d;
        logic [3:0][7:0]  b;
    } item_t;

    item_t exp_q[$];
    int n_chk = 0, n_bad = 0;
    int retry_budget = 0;
    bit bad_retry = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic item_t mk(input int id, input logic [1:0] cls, input int beats);
        item_t it;
        it.desc  = {8'(cls), 24'h5A0000, 32'(id)};
        it.cls   = cls;
        it.beats = 3'(beats);
        for (int j = 0; j < 4; j++) begin
            it.d[j] = {32'(id), 32'hB000 + 32'(j)};
            it.b[j] = (beats == 1 && cls == 2'b00) ? 8'hF0 : 8'hFF;
        end
        return it;
    endfunction

    // Driver: offer one packet once the queue has room.
    task automatic send(input item_t it);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_cls = it.cls; in_desc = it.desc; in_beats = it.beats;
        in_data = it.d; in_be = it.b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_exp(input item_t it);
        send(it);
        exp_q.push_back(it);
    endtask

    // Monitor and application model: serve n accepted packets.
    task automatic serve(input int n, input bit wait_mode, input string tag);
        int got = 0;
        while (got < n) begin
            item_t e;
            logic [63:0] saved;
            int tmo = 0;
            @(negedge clk);
            while (!dsc_req && tmo < 200) begin @(negedge clk); tmo++; end
            check(dsc_req, tag, "presentation timeout", 64'(dsc_req), 64'd1);
            if (!dsc_req) return;
            if (np_mask)
                check(dsc_cls != 2'b01, "R3", "non-posted presented under mask", 64'(dsc_cls), 64'd0);
            if (dsc_cls == 2'b01 && retry_budget > 0) begin
                retry_budget--;
                dsc_retry = 1'b1;
                @(negedge clk);
                dsc_retry = 1'b0;
                check(!dsc_req, "R4", "retried request still presented", 64'(dsc_req), 64'd0);
                continue;
            end
            if (bad_retry && dsc_cls != 2'b01) begin
                bad_retry = 1'b0;
                saved = dsc_desc;
                dsc_retry = 1'b1;
                @(negedge clk);
                dsc_retry = 1'b0;
                check(dsc_req && dsc_desc == saved, "R5", "retry on posted took effect", dsc_desc, saved);
            end
            saved = dsc_desc;
            @(negedge clk);
            check(dsc_req && dsc_desc == saved, "R6", "descriptor not held", dsc_desc, saved);
            if (exp_q.size() == 0) begin
                check(1'b0, tag, "unexpected packet", dsc_desc, 64'd0);
                return;
            end
            e = exp_q.pop_front();
            check(dsc_desc == e.desc, tag, "descriptor order", dsc_desc, e.desc);
            check(dsc_cls == e.cls, tag, "class", 64'(dsc_cls), 64'(e.cls));
            check(dsc_dfr == (e.beats != 0), "R10", "data pending flag", 64'(dsc_dfr), 64'(e.beats != 0));
            dsc_ack = 1'b1;
            @(negedge clk);
            dsc_ack = 1'b0;
            if (e.beats != 0) begin
                int j = 0, cyc = 0;
                while (j < int'(e.beats)) begin
                    bit w;
                    check(dat_valid, "R7", "beat missing", 64'(dat_valid), 64'd1);
                    check(dat_out == e.d[j], "R7", "beat data", dat_out, e.d[j]);
                    check(dat_be == e.b[j], "R7", "beat enables", 64'(dat_be), 64'(e.b[j]));
                    check({crd_post, crd_np, crd_cpl} == 3'b000, "R8", "early credit",
                          64'({crd_post, crd_np, crd_cpl}), 64'd0);
                    w = wait_mode && (cyc % 2 == 0);
                    dat_wait = w;
                    cyc++;
                    if (!w) j++;
                    @(negedge clk);
                end
                dat_wait = 1'b0;
            end
            check({crd_post, crd_np, crd_cpl} ==
                  {e.cls == 2'b00, e.cls == 2'b01, e.cls == 2'b10}, "R8", "credit pulse",
                  64'({crd_post, crd_np, crd_cpl}),
                  64'({e.cls == 2'b00, e.cls == 2'b01, e.cls == 2'b10}));
            check(!dat_valid, "R8", "data still valid at credit", 64'(dat_valid), 64'd0);
            got++;
        end
    endtask

    task automatic idle_check(input int cycles, input string tag);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            check(!dsc_req, tag, "unexpected presentation", 64'(dsc_req), 64'd0);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        item_t a, b, c, d;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!dsc_req && !dat_valid, "R1", "outputs idle in reset", 64'({dsc_req, dat_valid}), 64'd0);
        check({crd_post, crd_np, crd_cpl} == 3'b000, "R1", "credits in reset",
              64'({crd_post, crd_np, crd_cpl}), 64'd0);
        check(in_ready, "R1", "ready in reset", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: arrival order across classes and beat counts
        send_exp(mk(1, 2'b00, 1));
        send_exp(mk(2, 2'b10, 4));
        send_exp(mk(3, 2'b01, 0));
        send_exp(mk(4, 2'b00, 2));
        send_exp(mk(5, 2'b10, 0));
        serve(5, 1'b0, "R2");
        // R7: wait states hold beats
        send_exp(mk(6, 2'b10, 3));
        send_exp(mk(7, 2'b00, 4));
        serve(2, 1'b1, "R7");

        // R3: mask holds back non-posted, others flow
        @(negedge clk); np_mask = 1'b1;
        a = mk(10, 2'b01, 1);
        send(a);
        send_exp(mk(11, 2'b00, 1));
        send_exp(mk(12, 2'b10, 2));
        serve(2, 1'b0, "R3");
        idle_check(6, "R3");
        np_mask = 1'b0;
        exp_q.push_back(a);
        serve(1, 1'b0, "R3");

        // R4: one retry lets the posted packet pass, non-posted order kept
        a = mk(20, 2'b01, 0); b = mk(21, 2'b00, 1); c = mk(22, 2'b01, 2); d = mk(23, 2'b10, 1);
        send(a); send(b); send(c); send(d);
        exp_q.push_back(b); exp_q.push_back(a); exp_q.push_back(c); exp_q.push_back(d);
        retry_budget = 1;
        serve(4, 1'b0, "R4");

        // R4: two retries let both bypassing packets pass
        a = mk(30, 2'b01, 1); b = mk(31, 2'b00, 0); c = mk(32, 2'b01, 0); d = mk(33, 2'b10, 2);
        send(a); send(b); send(c); send(d);
        exp_q.push_back(b); exp_q.push_back(d); exp_q.push_back(a); exp_q.push_back(c);
        retry_budget = 2;
        serve(4, 1'b0, "R4");

        // R11: lone retried request comes back
        retry_budget = 1;
        send_exp(mk(40, 2'b01, 1));
        serve(1, 1'b0, "R11");
        check(retry_budget == 0, "R11", "retry not exercised", 64'(retry_budget), 64'd0);

        // R5: retry on a posted packet is ignored
        bad_retry = 1'b1;
        send_exp(mk(50, 2'b00, 1));
        serve(1, 1'b0, "R5");

        // R9: full queue refuses and drops a ninth packet
        for (int k = 0; k < 8; k++) send_exp(mk(60 + k, 2'b00, 1));
        @(negedge clk);
        check(!in_ready, "R9", "ready while full", 64'(in_ready), 64'd0);
        a = mk(99, 2'b00, 1);
        in_valid = 1'b1; in_cls = a.cls; in_desc = a.desc; in_beats = a.beats;
        in_data = a.d; in_be = a.b;
        @(negedge clk);
        in_valid = 1'b0;
        serve(8, 1'b0, "R9");
        idle_check(10, "R9");
        check(in_ready, "R9", "ready after drain", 64'(in_ready), 64'd1);
        check(exp_q.size() == 0, "R2", "expected items left", 64'(exp_q.size()), 64'd0);

        finish_run();
    end
endmodule